// File: doc/BRIEF.md
# Serial Line Transmitter with Format Control

This block turns bytes into an asynchronous serial bit stream. Bytes arrive over a valid/ready write port and are queued in a small buffer that can be run as a multi-entry queue or, when queueing is switched off, as a single holding slot. A shift engine takes one byte at a time, frames it with a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit and one or two high stop bits, and drives it onto the line. Every bit lasts a fixed number of oversample ticks, and the tick comes from an external baud-rate generator.

The line format (word length, parity on or off, even or odd parity, forced parity, stop-bit count) is sampled when each character starts, so a change takes effect from the next character. A character starts only if the block-wide enable and the transmit enable are both set, and no break is requested. When the clear-to-send gate is on, the clear-to-send input must also be high. A break request lets the character in flight finish and then holds the line low. Back-pressure on the write port is simple: `in_ready` is high exactly when the buffer is not full, a byte is taken on a clock edge where `in_valid` and `in_ready` are both high, and a byte offered while `in_ready` is low is dropped, not held. The full and empty flags report the buffer in whichever mode is selected.

Top module: `utx_line_tx`

## Requirements
- R1: After reset `txd` is 1, `busy` is 0, `fifo_empty` is 1, `fifo_full` is 0 and `in_ready` is 1. With no character in flight and `brk` low, `txd` is 1.
- R2: A frame begins with one low start bit, followed by the data bits least significant first. The number of data bits is 5 plus the value of `word_len` (code 0 gives 5 bits, code 3 gives 8 bits). Data bits above the word length are not sent. Each bit lasts OSR pulses of `tick`, and the frame does not advance while `tick` is low.
- R3: When `par_en` is 1, one parity bit follows the data bits. With `par_stick` at 0 it makes the count of ones in data plus parity even if `par_even` is 1, and odd if `par_even` is 0. With `par_stick` at 1 the parity bit is the inverse of `par_even`, regardless of the data.
- R4: The frame ends with one high stop bit, or with two when `two_stop` is 1.
- R5: `busy` rises when the start bit begins and falls only after the last stop bit has lasted its full length. With `tick` high every cycle it is high for exactly 16 cycles per frame bit.
- R6: No character starts unless `glb_en` and `tx_en` are both 1. A character that is not started stays queued.
- R7: When `cts_en` is 1, a character starts only while `cts` is 1. When `cts_en` is 0, `cts` is ignored.
- R8: While `brk` is 1, a frame already in flight completes unchanged, the line is then held at 0, and no new character starts. After `brk` returns to 0, queued characters are sent.
- R9: With `buf_en` at 1, `fifo_full` is set when DEPTH bytes are queued. With `buf_en` at 0, it is set when one byte is held. `fifo_empty` is set when nothing is held, and `in_ready` equals the inverse of `fifo_full`. A write offered while full is discarded.
- R10: Characters go out in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversample tick; OSR ticks make one bit time |
| in_valid | input | 1 | Write request on the byte port |
| in_ready | output | 1 | Byte port can accept a byte this cycle |
| in_data | input | 8 | Byte to queue |
| buf_en | input | 1 | 1: multi-entry queue, 0: single holding slot |
| fifo_full | output | 1 | Buffer full in the selected mode |
| fifo_empty | output | 1 | Buffer holds nothing |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Append a parity bit |
| par_even | input | 1 | Even parity select (and forced value select) |
| par_stick | input | 1 | Force the parity bit to the inverse of par_even |
| two_stop | input | 1 | Send two stop bits |
| brk | input | 1 | Hold the line low after the current frame |
| glb_en | input | 1 | Block-wide enable |
| tx_en | input | 1 | Transmit enable |
| cts_en | input | 1 | Gate character starts on cts |
| cts | input | 1 | Clear to send, active high |
| txd | output | 1 | Serial output |
| busy | output | 1 | A frame is being shifted out |

## Verification
The bound checker watches the cycle-level rules on every clock. Every frame opens low and closes high. Nothing starts while the enables, the clear-to-send gate or a break request forbid it. The line stays low during an idle break. A full buffer stays full while nothing drains it, and a single-slot buffer reports full as soon as it holds a byte. Only the bench's scenarios can show the rest: the exact bit pattern of a frame for each word length, parity mode and stop count, the busy duration, dropping of writes offered while full, and the order in which queued bytes leave.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int DATA_W = 8;
  localparam int MIN_W  = 5;
  localparam int WLEN_W = 2;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } tx_state_e;

  typedef struct packed {
    logic [WLEN_W-1:0] wlen;
    logic              par_en;
    logic              par_even;
    logic              par_stick;
    logic              two_stop;
  } line_fmt_t;
endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buffered,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= bump(wptr);
      if (rd_en) rptr <= bump(rptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign rd_data = mem[rptr];
  assign empty   = (count == '0);
  // single-slot mode: any held byte fills the buffer
  assign full    = buffered ? (count == CW'(DEPTH)) : !empty;
endmodule

// File: rtl/utx_parity.sv
module utx_parity
  import utx_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  input  logic [WLEN_W-1:0] wlen,
  input  logic              even,
  input  logic              stick,
  output logic              pbit
);
  logic [DATA_W-1:0] keep;

  // bits below the minimum width always count, the rest depend on wlen
  for (genvar i = 0; i < DATA_W; i++) begin : g_keep
    if (i < MIN_W) begin : g_fixed
      assign keep[i] = 1'b1;
    end else begin : g_opt
      assign keep[i] = (wlen >= WLEN_W'(i - MIN_W + 1));
    end
  end

  logic ones_odd;
  assign ones_odd = ^(data & keep);

  always_comb begin
    if (stick)     pbit = !even;
    else if (even) pbit = ones_odd;
    else           pbit = !ones_odd;
  end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              launch_ok,
  input  logic              head_valid,
  input  logic [DATA_W-1:0] head_data,
  input  line_fmt_t         fmt,
  input  logic              par_bit,
  input  logic              brk,
  output logic              pop,
  output logic              txd,
  output logic              busy
);
  localparam int TW = (OSR > 1) ? $clog2(OSR) : 1;

  tx_state_e         st;
  logic [TW-1:0]     tcnt;
  logic [DATA_W-1:0] sh;
  logic [IDX_W-1:0]  bidx;
  logic              stop_idx;
  logic              par_q;
  line_fmt_t         fmt_q;
  logic              bit_end;
  logic [IDX_W-1:0]  last_idx;

  assign bit_end  = tick && (tcnt == TW'(OSR - 1));
  assign last_idx = IDX_W'(MIN_W - 1) + IDX_W'(fmt_q.wlen);
  assign pop      = (st == ST_IDLE) && head_valid && launch_ok;
  assign busy     = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      tcnt     <= '0;
      sh       <= '0;
      bidx     <= '0;
      stop_idx <= 1'b0;
      par_q    <= 1'b0;
      fmt_q    <= '0;
    end else if (st == ST_IDLE) begin
      if (pop) begin
        st       <= ST_START;
        tcnt     <= '0;
        sh       <= head_data;
        bidx     <= '0;
        stop_idx <= 1'b0;
        par_q    <= par_bit;
        fmt_q    <= fmt;
      end
    end else begin
      if (tick) tcnt <= bit_end ? '0 : tcnt + 1'b1;
      if (bit_end) begin
        case (st)
          ST_START: st <= ST_DATA;
          ST_DATA: begin
            sh <= sh >> 1;
            if (bidx == last_idx) st <= fmt_q.par_en ? ST_PAR : ST_STOP;
            else                  bidx <= bidx + 1'b1;
          end
          ST_PAR: st <= ST_STOP;
          ST_STOP: begin
            if (fmt_q.two_stop && !stop_idx) stop_idx <= 1'b1;
            else                             st <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (st)
      ST_IDLE:  txd = !brk;
      ST_START: txd = 1'b0;
      ST_DATA:  txd = sh[0];
      ST_PAR:   txd = par_q;
      ST_STOP:  txd = 1'b1;
      default:  txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/utx_line_tx.sv
module utx_line_tx
  import utx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int OSR   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       buf_en,
  output logic       fifo_full,
  output logic       fifo_empty,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic       two_stop,
  input  logic       brk,
  input  logic       glb_en,
  input  logic       tx_en,
  input  logic       cts_en,
  input  logic       cts,
  output logic       txd,
  output logic       busy
);
  logic [DATA_W-1:0] head;
  logic              pop;
  logic              wr_go;
  logic              launch_ok;
  logic              pbit;
  line_fmt_t         fmt;

  assign in_ready  = !fifo_full;
  assign wr_go     = in_valid && in_ready;
  assign launch_ok = glb_en && tx_en && (!cts_en || cts) && !brk;

  always_comb begin
    fmt.wlen      = word_len;
    fmt.par_en    = par_en;
    fmt.par_even  = par_even;
    fmt.par_stick = par_stick;
    fmt.two_stop  = two_stop;
  end

  utx_fifo #(.DW(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .buffered (buf_en),
    .wr_en    (wr_go),
    .wr_data  (in_data),
    .rd_en    (pop),
    .rd_data  (head),
    .full     (fifo_full),
    .empty    (fifo_empty)
  );

  utx_parity u_par (
    .data  (head),
    .wlen  (word_len),
    .even  (par_even),
    .stick (par_stick),
    .pbit  (pbit)
  );

  utx_shifter #(.OSR(OSR)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .launch_ok  (launch_ok),
    .head_valid (!fifo_empty),
    .head_data  (head),
    .fmt        (fmt),
    .par_bit    (pbit),
    .brk        (brk),
    .pop        (pop),
    .txd        (txd),
    .busy       (busy)
  );
endmodule

// File: rtl/utx_line_tx_chk.sv
module utx_line_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic buf_en,
  input logic fifo_full,
  input logic fifo_empty,
  input logic brk,
  input logic glb_en,
  input logic tx_en,
  input logic cts_en,
  input logic cts,
  input logic txd,
  input logic busy
);
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |-> txd);

  a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !txd);

  a_r5_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(txd));

  a_r6_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(glb_en && tx_en)) |=> !busy);

  a_r7_cts_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cts_en && !cts) |=> !busy);

  a_r8_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !busy) |-> !txd);

  a_r8_no_start_break: assert property (@(posedge clk) disable iff (!rst_n)
    (brk && !busy) |=> !busy);

  a_r9_full_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && !busy && !(glb_en && tx_en)) |=> fifo_full);

  a_r9_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (!buf_en && !fifo_empty) |-> fifo_full);
endmodule

bind utx_line_tx utx_line_tx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .buf_en     (buf_en),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .brk        (brk),
  .glb_en     (glb_en),
  .tx_en      (tx_en),
  .cts_en     (cts_en),
  .cts        (cts),
  .txd        (txd),
  .busy       (busy)
);

// File: tb/utx_line_tx_bench.sv
`timescale 1ns/1ps
module utx_line_tx_bench;
  localparam int DEPTH = 4;
  localparam int OSR   = 16;
  localparam int NV    = 8;
  // {word_len, par_en, par_even, par_stick, two_stop, data}
  localparam logic [13:0] VEC [NV] = '{
    {2'd3, 4'b0000, 8'hA5},
    {2'd0, 4'b0000, 8'hFF},
    {2'd3, 4'b1100, 8'h07},
    {2'd3, 4'b1000, 8'h07},
    {2'd2, 4'b1101, 8'h81},
    {2'd1, 4'b1110, 8'h3F},
    {2'd3, 4'b1010, 8'h00},
    {2'd3, 4'b0001, 8'h5A}
  };

  logic clk = 0, rst_n = 0, tick = 1, in_valid = 0;
  logic [7:0] in_data = 0;
  logic buf_en = 1, par_en = 0, par_even = 0, par_stick = 0, two_stop = 0;
  logic brk = 0, glb_en = 1, tx_en = 1, cts_en = 0, cts = 0;
  logic [1:0] word_len = 2'd3;
  logic in_ready, fifo_full, fifo_empty, txd, busy;

  int n_vec = 0, n_bad = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  utx_line_tx #(.DEPTH(DEPTH), .OSR(OSR)) u_utx_line_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .buf_en(buf_en), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .word_len(word_len), .par_en(par_en), .par_even(par_even), .par_stick(par_stick),
    .two_stop(two_stop), .brk(brk), .glb_en(glb_en), .tx_en(tx_en), .cts_en(cts_en),
    .cts(cts), .txd(txd), .busy(busy)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int frame_len(input logic [13:0] v);
    return 1 + 5 + int'(v[13:12]) + int'(v[11]) + 1 + int'(v[8]);
  endfunction

  function automatic logic [11:0] frame_bits(input logic [13:0] v);
    logic [11:0] f = '0;
    int nb = 5 + int'(v[13:12]);
    int k;
    logic ones = 1'b0;
    f[0] = 1'b0;
    for (int i = 0; i < nb; i++) begin
      f[1 + i] = v[i];
      ones ^= v[i];
    end
    k = 1 + nb;
    if (v[11]) begin
      f[k] = v[9] ? !v[10] : (v[10] ? ones : !ones);
      k++;
    end
    f[k] = 1'b1;
    k++;
    if (v[8]) f[k] = 1'b1;
    return f;
  endfunction

  task automatic set_fmt(input logic [13:0] v);
    word_len = v[13:12]; par_en = v[11]; par_even = v[10];
    par_stick = v[9]; two_stop = v[8];
  endtask

  task automatic push(input logic [7:0] d);
    @(negedge clk);
    in_valid = 1; in_data = d;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic capture(input logic [13:0] v, input string req);
    bit seen = 0;
    int t0, n;
    logic [11:0] f;
    n = frame_len(v);
    f = frame_bits(v);
    for (int i = 0; i < 3000 && !seen; i++) begin
      if (busy) seen = 1;
      else @(negedge clk);
    end
    if (!seen) begin
      check_eq({req, " frame never started"}, 0, 1);
      return;
    end
    t0 = cyc;
    repeat (OSR / 2) @(negedge clk);
    for (int j = 0; j < n; j++) begin
      check_eq(req, int'(txd), int'(f[j]));
      if (j < n - 1) repeat (OSR) @(negedge clk);
    end
    while (busy) @(negedge clk);
    check_eq("R5 busy length", cyc - t0, OSR * n);
  endtask

  localparam logic [13:0] F8N1 = {2'd3, 4'b0000, 8'h00};

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1 txd", int'(txd), 1);
    check_eq("R1 busy", int'(busy), 0);
    check_eq("R1 empty", int'(fifo_empty), 1);
    check_eq("R1 full", int'(fifo_full), 0);
    check_eq("R1 ready", int'(in_ready), 1);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // table walk: R2 word lengths, R3 parity modes, R4 stop counts
    for (int v = 0; v < NV; v++) begin
      string req;
      req = VEC[v][11] ? "R3 parity frame" : (VEC[v][8] ? "R4 stop frame" : "R2 data frame");
      set_fmt(VEC[v]);
      push(VEC[v][7:0]);
      capture(VEC[v], req);
    end

    // R2: bit time counts ticks, not cycles
    set_fmt(F8N1);
    tick = 0;
    push(8'h01);
    repeat (100) @(negedge clk);
    check_eq("R2 stall busy", int'(busy), 1);
    check_eq("R2 stall start bit", int'(txd), 0);
    tick = 1;
    while (busy) @(negedge clk);
    check_eq("R1 idle high", int'(txd), 1);

    // R6: both enables needed
    tx_en = 0;
    push(8'h33);
    repeat (100) @(negedge clk);
    check_eq("R6 tx_en low", int'(busy), 0);
    check_eq("R6 still queued", int'(fifo_empty), 0);
    tx_en = 1; glb_en = 0;
    repeat (100) @(negedge clk);
    check_eq("R6 glb_en low", int'(busy), 0);
    glb_en = 1;
    capture({F8N1[13:8], 8'h33}, "R6 frame");

    // R7: clear-to-send gating
    cts_en = 1; cts = 0;
    push(8'h4C);
    repeat (100) @(negedge clk);
    check_eq("R7 cts low", int'(busy), 0);
    cts = 1;
    capture({F8N1[13:8], 8'h4C}, "R7 frame");
    cts_en = 0; cts = 0;
    push(8'h19);
    capture({F8N1[13:8], 8'h19}, "R7 gate off");

    // R8: break after current frame
    push(8'h11);
    push(8'h22);
    while (!busy) @(negedge clk);
    brk = 1;
    while (busy) @(negedge clk);
    check_eq("R8 line low", int'(txd), 0);
    repeat (150) @(negedge clk);
    check_eq("R8 no start", int'(busy), 0);
    check_eq("R8 held low", int'(txd), 0);
    check_eq("R8 still queued", int'(fifo_empty), 0);
    brk = 0;
    #1;
    check_eq("R8 release high", int'(txd), 1);
    capture({F8N1[13:8], 8'h22}, "R8 resume");

    // R9 / R10: queue mode, full flag, dropped write, order
    tx_en = 0;
    push(8'h10); push(8'h20); push(8'h30); push(8'h40);
    check_eq("R9 full", int'(fifo_full), 1);
    check_eq("R9 ready low", int'(in_ready), 0);
    check_eq("R9 not empty", int'(fifo_empty), 0);
    push(8'hEE);
    tx_en = 1;
    for (int k = 0; k < DEPTH; k++)
      capture({F8N1[13:8], 8'(8'h10 * (k + 1))}, "R10 order");
    repeat (300) @(negedge clk);
    check_eq("R9 dropped write", int'(busy), 0);
    check_eq("R9 empty", int'(fifo_empty), 1);

    // R9: single holding slot
    buf_en = 0; tx_en = 0;
    push(8'h5E);
    check_eq("R9 slot full", int'(fifo_full), 1);
    check_eq("R9 slot ready", int'(in_ready), 0);
    push(8'h77);
    tx_en = 1;
    capture({F8N1[13:8], 8'h5E}, "R9 slot frame");
    repeat (300) @(negedge clk);
    check_eq("R9 slot dropped", int'(busy), 0);
    check_eq("R9 slot empty", int'(fifo_empty), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule